// File: doc/BRIEF.md
# Keypad Dual-Tone Burst Generator

This block turns one telephone keypad digit into two square-wave frequency sources, one for the low (row) group and one for the high (column) group. Each source comes from the system clock through its own programmable half-period divider. The divide count is picked from a small table that the block works out at elaboration from the clock rate. An analog summing stage that follows the block turns the two square waves into the line signal.

A start strobe with a valid key request opens a burst. The burst runs for at least a fixed minimum time and goes on for as long as the key is held. A fixed silent gap follows every burst. A start that arrives during the gap is stored, and its burst begins as soon as the gap ends. If only one group is valid, only that group's output toggles. When tone mode is off, for example while the dialer sends pulses, the block makes no burst and keeps both outputs low.

Top module: `dtmf_burst_gen`

## Requirements
- R1: After a synchronous reset, `row_tone`, `col_tone` and `burst_on` are all low.
- R2: In a burst with `row_vld` high, `row_tone` is a square wave. Its period is 2*H clock cycles, where H = (CLK_HZ + f)/(2*f) in integer arithmetic and f is 697, 770, 852 or 941 Hz for `row_idx` 0, 1, 2 or 3.
- R3: In a burst with `col_vld` high and `col_idx` 0, 1 or 2, `col_tone` has a period of 2*H as in R2, with f equal to 1209, 1336 or 1477 Hz. A `col_idx` of 3 counts as no column key, and `col_tone` stays low.
- R4: Every generated frequency CLK_HZ/(2*H) lies within 0.8 % of its nominal value.
- R5: When only one group is valid at start, only that group's output toggles. The output of the other group stays low for the whole burst.
- R6: A burst (`burst_on` high) lasts exactly MIN = CLK_HZ*BURST_MS/1000 cycles when the key is released right after start. If `row_vld` or `col_vld` stays high beyond that time, the burst continues until the key is released.
- R7: After a burst, `burst_on` stays low for at least GAP = CLK_HZ*GAP_MS/1000 cycles. A start accepted during the gap begins its burst, with the key captured at that start, exactly GAP cycles after the previous burst ended.
- R8: Whenever `burst_on` is low, both tone outputs are low.
- R9: While `tone_en` is low, a start has no effect. Dropping `tone_en` during a burst ends the burst at the next clock edge.
- R10: A start with no valid group (no `row_vld`, and no `col_vld` with a column index of 0 to 2) is ignored, and no burst begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 3.579545 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| tone_en | input | 1 | High selects tone mode; low keeps the block silent |
| start | input | 1 | One-cycle request to send the presented key |
| row_idx | input | 2 | Row-group key index 0..3 |
| row_vld | input | 1 | Row group present / key held |
| col_idx | input | 2 | Column-group key index 0..2 (3 = none) |
| col_vld | input | 1 | Column group present / key held |
| row_tone | output | 1 | Row-group square wave |
| col_tone | output | 1 | Column-group square wave |
| burst_on | output | 1 | High while a burst is in progress |

## Verification
The bench sends all sixteen combinations of row index and column code as dual-group keys. For each one it measures both output periods from edge to edge, which separates a wrong table entry, a wrong index mapping and an off-by-one in the divider. Single-group keys and a start with no valid group show whether the unused output is gated and whether an empty request is rejected. A short press and a long hold separate the minimum-length rule from the hold rule. A start placed in the middle of a gap confirms that the start waits for the gap to end and that the key captured at that start is the one sent. A start in pulse mode and a mid-burst drop of `tone_en` test the mode gating.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_GAP} burst_st_e;

  // nominal low-group frequency for a row index
  function automatic int row_hz(input int idx);
    case (idx)
      0:       return 697;
      1:       return 770;
      2:       return 852;
      default: return 941;
    endcase
  endfunction

  // nominal high-group frequency for a column index
  function automatic int col_hz(input int idx);
    case (idx)
      0:       return 1209;
      1:       return 1336;
      default: return 1477;
    endcase
  endfunction

  // rounded half-period in clock cycles
  function automatic int half_cnt(input int clk_hz, input int f);
    return (clk_hz + f) / (2 * f);
  endfunction

endpackage

// File: rtl/dtmf_tone_div.sv
module dtmf_tone_div #(
  parameter int HALF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [HALF_W-1:0] half,
  output logic              wave
);

  logic [HALF_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (cnt == half - HALF_W'(1)) begin
      cnt  <= '0;
      wave <= ~wave;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end

endmodule

// File: rtl/dtmf_burst_timer.sv
module dtmf_burst_timer
  import dtmf_pkg::*;
#(
  parameter int MIN_CYC = 1000,
  parameter int GAP_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic tone_en,
  input  logic start,
  input  logic req_ok,
  input  logic held,
  output logic capture,
  output logic in_burst,
  output logic stay
);

  localparam int LONGEST = (MIN_CYC > GAP_CYC) ? MIN_CYC : GAP_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  burst_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             accept;

  assign accept  = tone_en && start && req_ok;
  assign capture = accept && (st_q != ST_BURST);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (!tone_en) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      pend_d = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_d  = ST_BURST;
            cnt_d = '0;
          end
        end
        ST_BURST: begin
          if (cnt_q == CNT_W'(MIN_CYC - 1)) begin
            if (!held) begin
              st_d  = ST_GAP;
              cnt_d = '0;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (accept) pend_d = 1'b1;
          if (cnt_q == CNT_W'(GAP_CYC - 1)) begin
            cnt_d = '0;
            if (pend_q || accept) begin
              st_d   = ST_BURST;
              pend_d = 1'b0;
            end else begin
              st_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign in_burst = (st_q == ST_BURST);
  assign stay     = (st_d == ST_BURST);

endmodule

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ   = 3579545,
  parameter int BURST_MS = 93,
  parameter int GAP_MS   = 93
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tone_en,
  input  logic       start,
  input  logic [1:0] row_idx,
  input  logic       row_vld,
  input  logic [1:0] col_idx,
  input  logic       col_vld,
  output logic       row_tone,
  output logic       col_tone,
  output logic       burst_on
);

  localparam int MIN_CYC = (CLK_HZ * BURST_MS) / 1000;
  localparam int GAP_CYC = (CLK_HZ * GAP_MS) / 1000;
  localparam int HALF_W  = $clog2(half_cnt(CLK_HZ, 697) + 1);
  localparam int N_KEY   = 4;

  logic [HALF_W-1:0] row_tab [N_KEY];
  logic [HALF_W-1:0] col_tab [N_KEY];

  for (genvar g = 0; g < N_KEY; g++) begin : g_tab
    localparam int RH = half_cnt(CLK_HZ, row_hz(g));
    localparam int CH = half_cnt(CLK_HZ, col_hz(g));
    assign row_tab[g] = HALF_W'(RH);
    assign col_tab[g] = HALF_W'(CH);
  end

  logic       col_ok, req_ok, held;
  logic       capture, in_burst, stay;
  logic [1:0] row_sel, col_sel;
  logic       row_on, col_on;

  assign col_ok = col_vld && (col_idx != 2'd3);
  assign req_ok = row_vld || col_ok;
  assign held   = row_vld || col_vld;

  dtmf_burst_timer #(
    .MIN_CYC(MIN_CYC),
    .GAP_CYC(GAP_CYC)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .tone_en (tone_en),
    .start   (start),
    .req_ok  (req_ok),
    .held    (held),
    .capture (capture),
    .in_burst(in_burst),
    .stay    (stay)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_sel <= '0;
      col_sel <= '0;
      row_on  <= 1'b0;
      col_on  <= 1'b0;
    end else if (capture) begin
      row_sel <= row_idx;
      col_sel <= col_idx;
      row_on  <= row_vld;
      col_on  <= col_ok;
    end
  end

  dtmf_tone_div #(.HALF_W(HALF_W)) row_div_i (
    .clk (clk),
    .rst (rst),
    .en  (in_burst && stay && row_on),
    .half(row_tab[row_sel]),
    .wave(row_tone)
  );

  dtmf_tone_div #(.HALF_W(HALF_W)) col_div_i (
    .clk (clk),
    .rst (rst),
    .en  (in_burst && stay && col_on),
    .half(col_tab[col_sel]),
    .wave(col_tone)
  );

  assign burst_on = in_burst;

endmodule

// File: rtl/dtmf_burst_gen_chk.sv
module dtmf_burst_gen_chk #(
  parameter int MIN_CYC = 1000,
  parameter int GAP_CYC = 1000
) (
  input logic clk,
  input logic rst,
  input logic tone_en,
  input logic row_tone,
  input logic col_tone,
  input logic burst_on
);

  logic [31:0] hi_len, lo_len;
  logic        prev_on, prev_en, normal_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_len     <= '0;
      lo_len     <= '0;
      prev_on    <= 1'b0;
      prev_en    <= 1'b0;
      normal_end <= 1'b0;
    end else begin
      hi_len  <= burst_on ? hi_len + 32'd1 : 32'd0;
      lo_len  <= burst_on ? 32'd0 : lo_len + 32'd1;
      prev_on <= burst_on;
      prev_en <= tone_en;
      if (!tone_en)                  normal_end <= 1'b0;
      else if (prev_on && !burst_on) normal_end <= prev_en;
    end
  end

  // R8
  tone_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !burst_on |-> (!row_tone && !col_tone));

  // R9
  pulse_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tone_en |=> !burst_on);

  // R6
  min_burst_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(burst_on) && $past(tone_en)) |-> (hi_len >= 32'(MIN_CYC)));

  // R7
  min_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(burst_on) && normal_end) |-> (lo_len >= 32'(GAP_CYC)));

endmodule

bind dtmf_burst_gen dtmf_burst_gen_chk #(
  .MIN_CYC(MIN_CYC),
  .GAP_CYC(GAP_CYC)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .tone_en (tone_en),
  .row_tone(row_tone),
  .col_tone(col_tone),
  .burst_on(burst_on)
);

// File: tb/dtmf_burst_gen_tb_top.sv
`timescale 1ns/1ps
module dtmf_burst_gen_tb_top;

  localparam int CLK_HZ   = 357954;
  localparam int BURST_MS = 6;
  localparam int GAP_MS   = 2;
  localparam int MIN      = (CLK_HZ * BURST_MS) / 1000;
  localparam int GAP      = (CLK_HZ * GAP_MS) / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tone_en = 1'b1;
  logic start = 1'b0;
  logic [1:0] row_idx = '0;
  logic row_vld = 1'b0;
  logic [1:0] col_idx = '0;
  logic col_vld = 1'b0;
  logic row_tone, col_tone, burst_on;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dtmf_burst_gen #(.CLK_HZ(CLK_HZ), .BURST_MS(BURST_MS), .GAP_MS(GAP_MS)) dut_i (
    .clk(clk), .rst(rst), .tone_en(tone_en), .start(start),
    .row_idx(row_idx), .row_vld(row_vld), .col_idx(col_idx), .col_vld(col_vld),
    .row_tone(row_tone), .col_tone(col_tone), .burst_on(burst_on)
  );

  // passive monitor, sampled on the falling edge
  longint cyc = 0;
  longint row_last = -1, col_last = -1;
  int row_per = 0, col_per = 0, row_rises = 0, col_rises = 0;
  int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0, bursts = 0, quiet_bad = 0;
  logic p_row = 0, p_col = 0, p_on = 0;

  always @(negedge clk) begin
    cyc++;
    if (row_tone && !p_row) begin
      if (row_last >= 0) row_per = int'(cyc - row_last);
      row_last = cyc; row_rises++;
    end
    if (col_tone && !p_col) begin
      if (col_last >= 0) col_per = int'(cyc - col_last);
      col_last = cyc; col_rises++;
    end
    if (!burst_on) begin
      row_last = -1; col_last = -1;
      if (row_tone || col_tone) quiet_bad++;
    end
    if (burst_on && !p_on) begin last_lo = lo_run; bursts++; end
    if (!burst_on && p_on) last_hi = hi_run;
    if (burst_on) begin hi_run++; lo_run = 0; end else begin lo_run++; hi_run = 0; end
    p_row = row_tone; p_col = col_tone; p_on = burst_on;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rf(input int i);
    return (i == 0) ? 697 : (i == 1) ? 770 : (i == 2) ? 852 : 941;
  endfunction
  function automatic int cf(input int i);
    return (i == 0) ? 1209 : (i == 1) ? 1336 : 1477;
  endfunction
  function automatic int exp_per(input int f);
    return 2 * ((CLK_HZ + f) / (2 * f));
  endfunction
  function automatic bit in_tol(input int f, input int per);
    longint d;
    d = longint'(CLK_HZ) - longint'(f) * per;
    if (d < 0) d = -d;
    return (d * 1000) <= (longint'(8) * f * per);
  endfunction

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // short press: key valid only together with start
  task automatic press(input int r, input int c, input bit rv, input bit cv);
    @(negedge clk);
    row_idx = 2'(r); col_idx = 2'(c); row_vld = rv; col_vld = cv; start = 1'b1;
    @(negedge clk);
    start = 1'b0; row_vld = 1'b0; col_vld = 1'b0;
  endtask

  initial begin
    #1_900_000;
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rb, cb, bb;
    wait_cyc(4);
    // R1
    chk(!row_tone && !col_tone && !burst_on, "R1 reset outputs", {row_tone, col_tone, burst_on}, 0);
    rst = 1'b0;
    wait_cyc(3);

    // dual-group sweep over every row and column code
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        cb = col_rises;
        press(r, c, 1'b1, 1'b1);
        wait_cyc(MIN - 5);
        chk(row_per == exp_per(rf(r)), "R2 row period", row_per, exp_per(rf(r)));
        chk(in_tol(rf(r), row_per), "R4 row tolerance", row_per, exp_per(rf(r)));
        if (c < 3) begin
          chk(col_per == exp_per(cf(c)), "R3 column period", col_per, exp_per(cf(c)));
          chk(in_tol(cf(c), col_per), "R4 column tolerance", col_per, exp_per(cf(c)));
        end else begin
          chk(col_rises == cb, "R3 column code 3 silent", col_rises - cb, 0);
        end
        wait_cyc(GAP + 30);
        chk(last_hi == MIN, "R6 short burst length", last_hi, MIN);
      end
    end

    // R5 column only, then row only
    rb = row_rises;
    press(0, 1, 1'b0, 1'b1);
    wait_cyc(MIN - 5);
    chk(row_rises == rb, "R5 row silent in column-only burst", row_rises - rb, 0);
    chk(col_per == exp_per(cf(1)), "R5 column-only period", col_per, exp_per(cf(1)));
    wait_cyc(GAP + 30);
    cb = col_rises;
    press(2, 0, 1'b1, 1'b0);
    wait_cyc(MIN - 5);
    chk(col_rises == cb, "R5 column silent in row-only burst", col_rises - cb, 0);
    chk(row_per == exp_per(rf(2)), "R5 row-only period", row_per, exp_per(rf(2)));
    wait_cyc(GAP + 30);

    // R10 start with no valid group
    bb = bursts;
    press(1, 3, 1'b1 & 1'b0, 1'b1);
    wait_cyc(50);
    chk(bursts == bb && !burst_on, "R10 empty request ignored", bursts - bb, 0);

    // R6 long hold
    @(negedge clk);
    row_idx = 2'd3; col_idx = 2'd2; row_vld = 1'b1; col_vld = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_cyc(MIN + 499);
    row_vld = 1'b0; col_vld = 1'b0;
    wait_cyc(GAP + 30);
    chk(last_hi >= MIN + 498 && last_hi <= MIN + 502, "R6 held burst length", last_hi, MIN + 500);

    // R7 start during the gap is deferred
    press(0, 0, 1'b1, 1'b1);
    wait_cyc(MIN + 100);
    chk(!burst_on, "R7 in gap", burst_on, 0);
    press(3, 1, 1'b1, 1'b1);
    wait_cyc(GAP);
    chk(burst_on, "R7 deferred burst started", burst_on, 1);
    chk(last_lo == GAP, "R7 gap length", last_lo, GAP);
    wait_cyc(MIN - 200);
    chk(row_per == exp_per(rf(3)), "R7 deferred key row", row_per, exp_per(rf(3)));
    chk(col_per == exp_per(cf(1)), "R7 deferred key column", col_per, exp_per(cf(1)));
    wait_cyc(GAP + 300);

    // R9 pulse mode
    tone_en = 1'b0;
    bb = bursts; rb = row_rises; cb = col_rises;
    press(1, 1, 1'b1, 1'b1);
    wait_cyc(300);
    chk(bursts == bb && row_rises == rb && col_rises == cb, "R9 no burst in pulse mode",
        bursts - bb, 0);
    tone_en = 1'b1;
    wait_cyc(5);
    press(1, 1, 1'b1, 1'b1);
    wait_cyc(300);
    chk(burst_on, "R9 burst running before abort", burst_on, 1);
    tone_en = 1'b0;
    @(negedge clk);
    chk(!burst_on && !row_tone && !col_tone, "R9 abort on mode drop",
        {burst_on, row_tone, col_tone}, 0);
    tone_en = 1'b1;
    wait_cyc(10);

    // R8 tones never active outside a burst
    chk(quiet_bad == 0, "R8 tones low outside burst", quiet_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule